// File: doc/BRIEF.md
# Bus-Slave Printer Output Port

This block is a parallel output port that sits as a slave on a synchronous processor bus where one transfer takes several clock cycles. It watches the bus address; when the upper address bits name this port, a small two-state machine (waiting / answering) takes the transfer, and in the cycle it answers it raises a one-cycle acknowledge toward the bus master.

On the device side it drives an 8-bit data byte to a printer together with a one-cycle strobe that marks new data. The printer returns a level that says it is free to accept a byte, and that level sets a ready flag inside the port. A write to the data address loads the byte, fires the strobe and clears the flag. A read of the status address returns the flag on data bit 1. A read of the data address returns the byte last written.

The lowest address bit picks the register: 0 is the data register, 1 is the status register. A transfer spans three cycles. The master drives the request, the address and the direction in cycle 1. The port decides to take the transfer and loads data in cycle 2. The acknowledge and any read data appear in cycle 3. While the port is not answering, its read-data output is all zero, so it can be ORed onto a shared return path.

Top module: `prt_out_port`

## Requirements
- R1: After reset, `slave_rdy`, `prn_valid`, `bus_rdata`, `prn_data` and the ready flag are all zero, so a status read returns 0x00.
- R2: A request whose address bits [15:1] differ from the base value gets no `slave_rdy` and does not change `prn_data`.
- R3: For a matching request first presented in cycle 1, `slave_rdy` is low in cycle 2, high in cycle 3 and low again in cycle 4.
- R4: A matching request held for many cycles gets exactly one `slave_rdy` pulse. A new transfer is taken only after the request has been dropped.
- R5: A write (`bus_wr`=1) to the data address (bit 0 = 0) places `bus_wdata` on `prn_data`, visible in the acknowledge cycle.
- R6: Each data-register write raises `prn_valid` for exactly one cycle, the acknowledge cycle. `prn_valid` is never high without `slave_rdy`.
- R7: `prn_idle` high at a clock edge sets the ready flag. A data-register write clears it, and the clear takes precedence over a set at the same edge.
- R8: A read of the status address (bit 0 = 1) returns the ready flag on bit 1, with all other bits zero, in the acknowledge cycle.
- R9: A read of the data address returns the current `prn_data` value in the acknowledge cycle.
- R10: `bus_rdata` is zero in every cycle in which `slave_rdy` is low.
- R11: A write to the status address is acknowledged, but it leaves `prn_data` unchanged and produces no `prn_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Master presents an address and command |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address; bits [15:1] are matched, bit 0 selects the register |
| bus_wdata | input | 8 | Write data from the master |
| bus_rdata | output | 8 | Read data, zero unless answering |
| slave_rdy | output | 1 | One-cycle acknowledge toward the master |
| prn_data | output | 8 | Byte held for the printer |
| prn_valid | output | 1 | One-cycle strobe: new byte present |
| prn_idle | input | 1 | Printer is free to accept a byte |

## Verification
Writes of several byte patterns (0xA5, 0x5A, 0xFF, 0x00) show whether the data path carries every bit, and a read of the data address after each write shows whether the value was kept. Status reads taken before and after the printer raises its free level, and again after a write, tell a set flag apart from a cleared one. A wrong-address write, a write to the status address and a request held for eight cycles each differ from a good transfer in only one respect. These cases separate a faulty address decode, a faulty register select and a retriggering state machine.

// File: rtl/prt_out_pkg.sv
package prt_out_pkg;

  typedef enum logic {
    PS_WAIT = 1'b0,
    PS_ANSWER = 1'b1
  } port_state_e;

  typedef struct packed {
    logic hit;
    logic wr;
    logic reg_sel;
  } bus_cmd_t;

endpackage

// File: rtl/prt_addr_match.sv
module prt_addr_match #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-2:0] BASE_HI = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  output prt_out_pkg::bus_cmd_t  cmd_q
);
  import prt_out_pkg::*;

  localparam int HI_W = ADDR_W - 1;

  function automatic logic upper_hit(input logic [ADDR_W-1:0] a,
                                     input logic [HI_W-1:0] base);
    return a[ADDR_W-1:1] == base;
  endfunction

  bus_cmd_t cmd_d;

  always_comb begin
    cmd_d.hit     = req && upper_hit(addr, BASE_HI);
    cmd_d.wr      = wr;
    cmd_d.reg_sel = addr[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  assert_no_stray_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.hit |-> $past(req));

endmodule

// File: rtl/prt_timing_fsm.sv
module prt_timing_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_q,
  output logic go,
  output logic answering
);
  import prt_out_pkg::*;

  port_state_e state_q, state_d;
  logic        served_q;

  assign go = hit_q && (state_q == PS_WAIT) && !served_q;

  always_comb begin
    state_d = PS_WAIT;
    if (state_q == PS_WAIT && go) state_d = PS_ANSWER;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= PS_WAIT;
      served_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (go)          served_q <= 1'b1;
      else if (!hit_q) served_q <= 1'b0;
    end
  end

  assign answering = (state_q == PS_ANSWER);

  assert_go_then_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> answering);

  assert_answer_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    answering |=> !answering);

  assert_held_no_retrigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (answering && hit_q) |=> !go);

endmodule

// File: rtl/prt_data_path.sv
module prt_data_path #(
  parameter int DATA_W = 8,
  parameter int FLAG_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              wr_q,
  input  logic              reg_sel_q,
  input  logic [DATA_W-1:0] wdata,
  input  logic              prn_idle,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_valid,
  output logic [DATA_W-1:0] rdata,
  output logic              ready_flag
);

  function automatic logic [DATA_W-1:0] status_word(input logic flag);
    logic [DATA_W-1:0] w;
    w = '0;
    w[FLAG_BIT] = flag;
    return w;
  endfunction

  logic load;
  logic rd_go;

  assign load  = go && wr_q && !reg_sel_q;
  assign rd_go = go && !wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prn_data   <= '0;
      prn_valid  <= 1'b0;
      ready_flag <= 1'b0;
      rdata      <= '0;
    end else begin
      prn_valid <= load;
      if (load) prn_data <= wdata;
      if (load)          ready_flag <= 1'b0;
      else if (prn_idle) ready_flag <= 1'b1;
      if (rd_go) rdata <= reg_sel_q ? status_word(ready_flag) : prn_data;
      else       rdata <= '0;
    end
  end

  assert_load_clears_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prn_valid |-> !ready_flag);

  assert_data_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> $stable(prn_data));

endmodule

// File: rtl/prt_out_port.sv
module prt_out_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int FLAG_BIT = 1,
  parameter logic [ADDR_W-2:0] BASE_HI = 15'h4800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              slave_rdy,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_valid,
  input  logic              prn_idle
);
  import prt_out_pkg::*;

  bus_cmd_t cmd_q;
  logic     go;
  logic     answering;
  logic     ready_flag;

  prt_addr_match #(.ADDR_W(ADDR_W), .BASE_HI(BASE_HI)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (bus_req),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .cmd_q (cmd_q)
  );

  prt_timing_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_q     (cmd_q.hit),
    .go        (go),
    .answering (answering)
  );

  prt_data_path #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .wr_q       (cmd_q.wr),
    .reg_sel_q  (cmd_q.reg_sel),
    .wdata      (bus_wdata),
    .prn_idle   (prn_idle),
    .prn_data   (prn_data),
    .prn_valid  (prn_valid),
    .rdata      (bus_rdata),
    .ready_flag (ready_flag)
  );

  assign slave_rdy = answering;

  assert_rdata_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_rdy |-> (bus_rdata == '0));

  assert_valid_in_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prn_valid |-> slave_rdy);

  assert_go_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> cmd_q.hit);

endmodule

// File: tb/prt_out_port_test.sv
`timescale 1ns/1ps
module prt_out_port_test;

  localparam logic [15:0] DATA_A = 16'h9000;
  localparam logic [15:0] STAT_A = 16'h9001;
  localparam logic [15:0] MISS_A = 16'h9100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_req = 1'b0;
  logic       bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       slave_rdy;
  logic [7:0] prn_data;
  logic       prn_valid;
  logic       prn_idle = 1'b0;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] rdata;
    logic [7:0] pdata;
    logic       valid;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  prt_out_port uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .slave_rdy(slave_rdy), .prn_data(prn_data), .prn_valid(prn_valid),
    .prn_idle(prn_idle)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops an expected item for every acknowledge; R10 quiet data otherwise
  always @(negedge clk) begin
    if (rst_n) begin
      if (slave_rdy) begin
        if (sb.size() == 0) begin
          check("R2/R4 unexpected ack", 8'd1, 8'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " rdata"}, bus_rdata, e.rdata);
          check({e.tag, " prn_data"}, prn_data, e.pdata);
          check({e.tag, " prn_valid R6"}, {7'd0, prn_valid}, {7'd0, e.valid});
        end
      end else if (bus_rdata != 8'd0) begin
        check("R10 rdata quiet", bus_rdata, 8'd0);
      end
    end
  end

  // driver: one transfer held for hold cycles; ack expected unless miss
  task automatic xfer(input logic [15:0] a, input logic w, input logic [7:0] d,
                      input int hold, input bit expect_ack, input exp_t e);
    @(negedge clk);
    bus_req = 1'b1; bus_addr = a; bus_wr = w; bus_wdata = d;
    if (expect_ack) sb.push_back(e);
    @(negedge clk);
    check("R3 no ack in cycle 2", {7'd0, slave_rdy}, 8'd0);
    @(negedge clk);
    check("R3 ack in cycle 3", {7'd0, slave_rdy}, {7'd0, expect_ack});
    @(negedge clk);
    check("R3 ack ends in cycle 4", {7'd0, slave_rdy}, 8'd0);
    for (int i = 3; i < hold; i++) @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic exp_t mk(logic [7:0] r, logic [7:0] p, logic v, string t);
    exp_t e;
    e.rdata = r; e.pdata = p; e.valid = v; e.tag = t;
    return e;
  endfunction

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 slave_rdy", {7'd0, slave_rdy}, 8'd0);
    check("R1 prn_valid", {7'd0, prn_valid}, 8'd0);
    check("R1 rdata", bus_rdata, 8'd0);
    check("R1 prn_data", prn_data, 8'd0);
    xfer(STAT_A, 1'b0, 8'h00, 3, 1, mk(8'h00, 8'h00, 1'b0, "R1 flag clear"));
    // printer free: sets flag (R7), read on bit 1 (R8)
    prn_idle = 1'b1;
    @(negedge clk); @(negedge clk);
    prn_idle = 1'b0;
    xfer(STAT_A, 1'b0, 8'h00, 3, 1, mk(8'h02, 8'h00, 1'b0, "R7 R8 flag set"));
    xfer(DATA_A, 1'b1, 8'hA5, 3, 1, mk(8'h00, 8'hA5, 1'b1, "R5 write A5"));
    check("R6 valid one cycle", {7'd0, prn_valid}, 8'd0);
    xfer(STAT_A, 1'b0, 8'h00, 3, 1, mk(8'h00, 8'hA5, 1'b0, "R7 flag cleared"));
    xfer(DATA_A, 1'b0, 8'h00, 3, 1, mk(8'hA5, 8'hA5, 1'b0, "R9 read A5"));
    xfer(STAT_A, 1'b1, 8'h3C, 3, 1, mk(8'h00, 8'hA5, 1'b0, "R11 status write"));
    check("R11 prn_data kept", prn_data, 8'hA5);
    xfer(MISS_A, 1'b1, 8'h11, 3, 0, mk(8'h00, 8'h00, 1'b0, "R2 miss"));
    check("R2 prn_data kept", prn_data, 8'hA5);
    xfer(DATA_A, 1'b1, 8'h5A, 8, 1, mk(8'h00, 8'h5A, 1'b1, "R4 held write"));
    xfer(DATA_A, 1'b0, 8'h00, 3, 1, mk(8'h5A, 8'h5A, 1'b0, "R9 read 5A"));
    xfer(DATA_A, 1'b1, 8'hFF, 3, 1, mk(8'h00, 8'hFF, 1'b1, "R5 write FF"));
    xfer(DATA_A, 1'b0, 8'h00, 3, 1, mk(8'hFF, 8'hFF, 1'b0, "R9 read FF"));
    // R7 clear wins over a simultaneous set
    prn_idle = 1'b1;
    xfer(DATA_A, 1'b1, 8'h00, 3, 1, mk(8'h00, 8'h00, 1'b1, "R5 write 00"));
    prn_idle = 1'b0;
    @(negedge clk);
    xfer(STAT_A, 1'b0, 8'h00, 3, 1, mk(8'h02, 8'h00, 1'b0, "R7 R8 flag set again"));
    repeat (4) @(negedge clk);
    check("R4 scoreboard drained", 8'(sb.size()), 8'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule